// File: doc/BRIEF.md
# Audio Frame Sequencer with Status

This block paces the slow-rate housekeeping of a sound generator. A free-running divider splits the CPU-rate clock into equal intervals of `DIV_CYCLES` clocks (7457 by default). At the close of each interval a step state machine advances one step and emits a one-cycle quarter-frame pulse, a half-frame pulse, or both. The channel units use these pulses to clock their envelopes, linear counters, length counters and sweeps. A control register write selects a four-step or a five-step sequence and can inhibit the frame interrupt.

The block also keeps two interrupt flags. The frame flag is set at the end of the last step of the four-step sequence. The DMC flag is set by a pulse from the sample channel. The block combines both flags with per-channel activity inputs into one 8-bit status word and drives an interrupt request line. Reading the status clears the frame flag. A write to the channel enable register clears the DMC flag.

The step state machine has five states, ST_STEP0 to ST_STEP4. The divider tick drives every transition.
- In four-step mode the machine runs ST_STEP0→ST_STEP1→ST_STEP2→ST_STEP3→ST_STEP0.
- In five-step mode ST_STEP3 goes to ST_STEP4, and ST_STEP4 goes to ST_STEP0.
- If ST_STEP4 is ticked while four-step mode is selected, the machine issues a quarter pulse only and returns to ST_STEP0.
- Without a tick the state holds.

Top module: `fs_frame_seq`

## Requirements
- R1: After reset the divider and step are cleared and four-step mode is selected with the frame interrupt enabled. Both flags are clear, `irq_out` is 0, no pulse is active, and `stat_rdata` shows only the activity inputs.
- R2: `quarter_pulse` and `half_pulse` are high only in the last cycle of each `DIV_CYCLES`-clock interval, and each lasts one cycle. Counting from the first clock edge after reset, the first pulses appear in cycle `DIV_CYCLES`.
- R3: In four-step mode every step gives a quarter pulse. Steps 1 and 3 also give a half pulse. After step 3 the sequence returns to step 0.
- R4: In five-step mode steps 0 to 3 give a quarter pulse and step 4 gives no pulse. Steps 0 and 2 give a half pulse. After step 4 the sequence returns to step 0.
- R5: The frame flag is set at the edge that ends step 3 in four-step mode, unless control bit 6 (inhibit) is set. It is never set in five-step mode.
- R6: A status read (`stat_rd` high at an edge) clears the frame flag at that edge. A control write with bit 6 set clears it as well, so later clearing the inhibit bit does not expose an old flag.
- R7: The `stat_rdata` layout is as follows:
  - bit 7: DMC flag
  - bit 6: frame flag AND NOT inhibit
  - bit 5: always 0
  - bit 4: `dmc_active`
  - bits 3..0: `chan_active` (noise, triangle, pulse 2, pulse 1)
- R8: A `dmc_irq_set` pulse sets the DMC flag. An `enable_wr` pulse clears it.
- R9: `irq_out` is high exactly when the frame flag is set and not inhibited, or when the DMC flag is set.
- R10: A set wins over a coincident status read (frame flag) and over a coincident `enable_wr` (DMC flag). An inhibit write that coincides with a frame set clears the flag and suppresses the set.
- R11: A control write restarts neither the divider nor the step count. Control bit 7 (1 = five-step) takes effect from the next step's decode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | CPU-rate clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ctrl_wr | input | 1 | Control register write strobe |
| ctrl_wdata | input | 8 | Control data: bit 7 five-step, bit 6 inhibit |
| stat_rd | input | 1 | Status read strobe; clears frame flag |
| enable_wr | input | 1 | Channel enable register write strobe; clears DMC flag |
| dmc_irq_set | input | 1 | DMC interrupt set pulse |
| dmc_active | input | 1 | DMC bytes remaining non-zero |
| chan_active | input | 4 | Noise, triangle, pulse 2, pulse 1 active |
| quarter_pulse | output | 1 | Quarter-frame clock pulse |
| half_pulse | output | 1 | Half-frame clock pulse |
| stat_rdata | output | 8 | Status read data |
| irq_out | output | 1 | Interrupt request |

## Verification
The assertions check several rules on every cycle:
- a half pulse always comes with a quarter pulse;
- pulses last a single cycle;
- the status bit 5 stays 0;
- `irq_out` agrees with the two status flag bits;
- a frame flag can appear only right after a half pulse;
- a read, an inhibit write or an enable write clears its flag on the next cycle.

Only the bench scenarios can show the step patterns of each mode, the spacing of the pulses, and the wrap points. They also cover the continuation of the step count across a mode change, the set-over-clear priority, and the fact that an inhibited flag is really cleared and not just masked.

// File: rtl/fs_pkg.sv
package fs_pkg;
    typedef enum logic [2:0] {
        ST_STEP0 = 3'd0,
        ST_STEP1 = 3'd1,
        ST_STEP2 = 3'd2,
        ST_STEP3 = 3'd3,
        ST_STEP4 = 3'd4
    } fs_step_e;

    localparam int CTRL_W       = 8;
    localparam int CTRL_MODE_B  = 7;
    localparam int CTRL_INH_B   = 6;
    localparam int STAT_W       = 8;
    localparam int NUM_CHAN     = 4;
endpackage

// File: rtl/fs_divider.sv
module fs_divider #(
    parameter int DIV_CYCLES = 7457
) (
    input  logic clk,
    input  logic rst_n,
    output logic tick
);
    localparam int CW = (DIV_CYCLES > 1) ? $clog2(DIV_CYCLES) : 1;
    localparam logic [CW-1:0] LAST = CW'(DIV_CYCLES - 1);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (cnt_q == LAST) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign tick = (cnt_q == LAST);
endmodule

// File: rtl/fs_step_fsm.sv
module fs_step_fsm
    import fs_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  logic five_mode,
    output logic quarter,
    output logic half,
    output logic frame_set
);
    fs_step_e state_q, state_d;

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_STEP0;
        end else begin
            state_q <= state_d;
        end
    end

    // Next state and decoded step outputs.
    always_comb begin
        logic q_dec, h_dec, f_dec;
        state_d = state_q;
        q_dec   = 1'b0;
        h_dec   = 1'b0;
        f_dec   = 1'b0;
        unique case (state_q)
            ST_STEP0: begin
                state_d = ST_STEP1;
                q_dec   = 1'b1;
                h_dec   = five_mode;
            end
            ST_STEP1: begin
                state_d = ST_STEP2;
                q_dec   = 1'b1;
                h_dec   = !five_mode;
            end
            ST_STEP2: begin
                state_d = ST_STEP3;
                q_dec   = 1'b1;
                h_dec   = five_mode;
            end
            ST_STEP3: begin
                state_d = five_mode ? ST_STEP4 : ST_STEP0;
                q_dec   = 1'b1;
                h_dec   = !five_mode;
                f_dec   = !five_mode;
            end
            ST_STEP4: begin
                state_d = ST_STEP0;
                q_dec   = !five_mode;
            end
            default: begin
                state_d = ST_STEP0;
            end
        endcase
        if (!tick) begin
            state_d = state_q;
        end
        quarter   = tick & q_dec;
        half      = tick & h_dec;
        frame_set = tick & f_dec;
    end
endmodule

// File: rtl/fs_irq_status.sv
module fs_irq_status
    import fs_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                frame_set,
    input  logic                inhibit,
    input  logic                inh_write,
    input  logic                stat_rd,
    input  logic                dmc_irq_set,
    input  logic                enable_wr,
    input  logic                dmc_active,
    input  logic [NUM_CHAN-1:0] chan_active,
    output logic [STAT_W-1:0]   stat_rdata,
    output logic                irq_out
);
    logic frame_flag_q, dmc_flag_q;
    logic frame_vis;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            frame_flag_q <= 1'b0;
        end else if (inh_write) begin
            frame_flag_q <= 1'b0;
        end else if (frame_set && !inhibit) begin
            frame_flag_q <= 1'b1;
        end else if (stat_rd) begin
            frame_flag_q <= 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dmc_flag_q <= 1'b0;
        end else if (dmc_irq_set) begin
            dmc_flag_q <= 1'b1;
        end else if (enable_wr) begin
            dmc_flag_q <= 1'b0;
        end
    end

    assign frame_vis  = frame_flag_q & !inhibit;
    assign stat_rdata = {dmc_flag_q, frame_vis, 1'b0, dmc_active, chan_active};
    assign irq_out    = frame_vis | dmc_flag_q;
endmodule

// File: rtl/fs_frame_seq.sv
module fs_frame_seq
    import fs_pkg::*;
#(
    parameter int DIV_CYCLES = 7457
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                ctrl_wr,
    input  logic [CTRL_W-1:0]   ctrl_wdata,
    input  logic                stat_rd,
    input  logic                enable_wr,
    input  logic                dmc_irq_set,
    input  logic                dmc_active,
    input  logic [NUM_CHAN-1:0] chan_active,
    output logic                quarter_pulse,
    output logic                half_pulse,
    output logic [STAT_W-1:0]   stat_rdata,
    output logic                irq_out
);
    logic five_mode_q, inhibit_q;
    logic tick, frame_set, inh_write;
    logic ctrl_unused_bits;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            five_mode_q <= 1'b0;
            inhibit_q   <= 1'b0;
        end else if (ctrl_wr) begin
            five_mode_q <= ctrl_wdata[CTRL_MODE_B];
            inhibit_q   <= ctrl_wdata[CTRL_INH_B];
        end
    end

    assign inh_write        = ctrl_wr & ctrl_wdata[CTRL_INH_B];
    assign ctrl_unused_bits = ^ctrl_wdata[CTRL_INH_B-1:0];

    fs_divider #(.DIV_CYCLES(DIV_CYCLES)) u_div (
        .clk   (clk),
        .rst_n (rst_n),
        .tick  (tick)
    );

    fs_step_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick      (tick),
        .five_mode (five_mode_q),
        .quarter   (quarter_pulse),
        .half      (half_pulse),
        .frame_set (frame_set)
    );

    fs_irq_status u_irq (
        .clk         (clk),
        .rst_n       (rst_n),
        .frame_set   (frame_set),
        .inhibit     (inhibit_q),
        .inh_write   (inh_write),
        .stat_rd     (stat_rd),
        .dmc_irq_set (dmc_irq_set),
        .enable_wr   (enable_wr),
        .dmc_active  (dmc_active),
        .chan_active (chan_active),
        .stat_rdata  (stat_rdata),
        .irq_out     (irq_out)
    );
endmodule

// File: rtl/fs_frame_seq_chk.sv
module fs_frame_seq_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       ctrl_wr,
    input logic       ctrl_inh_bit,
    input logic       stat_rd,
    input logic       enable_wr,
    input logic       dmc_irq_set,
    input logic       quarter_pulse,
    input logic       half_pulse,
    input logic [7:0] stat_rdata,
    input logic       irq_out
);
    AST_HALF_WITH_QUARTER: assert property (@(posedge clk) disable iff (!rst_n)
        half_pulse |-> quarter_pulse); // R4
    AST_QUARTER_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        quarter_pulse |=> !quarter_pulse); // R2
    AST_HALF_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        half_pulse |=> !half_pulse); // R2
    AST_STAT_BIT5_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        stat_rdata[5] == 1'b0); // R7
    AST_IRQ_MATCHES_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
        irq_out == (stat_rdata[7] | stat_rdata[6])); // R9
    AST_FRAME_AFTER_HALF: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(stat_rdata[6]) |-> $past(half_pulse)); // R5
    AST_READ_CLEARS_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_rd && !quarter_pulse) |=> !stat_rdata[6]); // R6
    AST_INHIBIT_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_wr && ctrl_inh_bit) |=> !stat_rdata[6]); // R6
    AST_ENWR_CLEARS_DMC: assert property (@(posedge clk) disable iff (!rst_n)
        (enable_wr && !dmc_irq_set) |=> !stat_rdata[7]); // R8
    AST_DMC_SET: assert property (@(posedge clk) disable iff (!rst_n)
        dmc_irq_set |=> stat_rdata[7]); // R10
endmodule

bind fs_frame_seq fs_frame_seq_chk u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .ctrl_wr       (ctrl_wr),
    .ctrl_inh_bit  (ctrl_wdata[6]),
    .stat_rd       (stat_rd),
    .enable_wr     (enable_wr),
    .dmc_irq_set   (dmc_irq_set),
    .quarter_pulse (quarter_pulse),
    .half_pulse    (half_pulse),
    .stat_rdata    (stat_rdata),
    .irq_out       (irq_out)
);

// File: tb/tb_fs_frame_seq.sv
`timescale 1ns/1ps
module tb_fs_frame_seq;
    localparam int DIV = 16;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ctrl_wr = 1'b0;
    logic [7:0] ctrl_wdata = 8'h00;
    logic       stat_rd = 1'b0;
    logic       enable_wr = 1'b0;
    logic       dmc_irq_set = 1'b0;
    logic       dmc_active = 1'b0;
    logic [3:0] chan_active = 4'h0;
    logic       quarter_pulse, half_pulse, irq_out;
    logic [7:0] stat_rdata;

    int n_chk = 0;
    int n_bad = 0;
    int cyc = 0;
    bit done = 0;

    always #4 clk = ~clk;

    fs_frame_seq #(.DIV_CYCLES(DIV)) dut (
        .clk(clk), .rst_n(rst_n), .ctrl_wr(ctrl_wr), .ctrl_wdata(ctrl_wdata),
        .stat_rd(stat_rd), .enable_wr(enable_wr), .dmc_irq_set(dmc_irq_set),
        .dmc_active(dmc_active), .chan_active(chan_active),
        .quarter_pulse(quarter_pulse), .half_pulse(half_pulse),
        .stat_rdata(stat_rdata), .irq_out(irq_out)
    );

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h (cycle %0d)", req, act, exp, cyc);
        end
    endtask

    task automatic tick;
        @(posedge clk);
        @(negedge clk);
        cyc++;
    endtask

    task automatic do_reset;
        rst_n = 1'b0;
        ctrl_wr = 0; stat_rd = 0; enable_wr = 0; dmc_irq_set = 0;
        chan_active = 0; dmc_active = 0;
        tick; tick;
        rst_n = 1'b1;
        cyc = 0;
    endtask

    // Advances to the last cycle of the current interval, checking silence
    // before it, and returns the pulses seen there.
    task automatic next_step(input string req, input logic exp_q, input logic exp_h);
        do begin
            tick;
            if ((cyc % DIV) != DIV - 1)
                check("R2 no pulse mid-interval", {6'd0, quarter_pulse, half_pulse}, 8'd0);
        end while ((cyc % DIV) != DIV - 1);
        check(req, {6'd0, quarter_pulse, half_pulse}, {6'd0, exp_q, exp_h});
    endtask

    task automatic do_ctrl(input logic [7:0] d);
        ctrl_wr = 1'b1; ctrl_wdata = d;
        tick;
        ctrl_wr = 1'b0;
    endtask

    task automatic t_reset;
        do_reset;
        check("R1 status after reset", stat_rdata, 8'h00);
        check("R1 irq after reset", {7'd0, irq_out}, 8'd0);
        check("R1 pulses after reset", {6'd0, quarter_pulse, half_pulse}, 8'd0);
    endtask

    task automatic t_four_step;
        do_reset;
        next_step("R3 step0", 1, 0);
        next_step("R3 step1", 1, 1);
        next_step("R3 step2", 1, 0);
        check("R5 flag not before step3 edge", {7'd0, irq_out}, 8'd0);
        next_step("R3 step3", 1, 1);
        tick;
        check("R5 frame flag set", stat_rdata, 8'h40);
        check("R9 irq from frame flag", {7'd0, irq_out}, 8'd1);
        stat_rd = 1'b1;
        tick;
        stat_rd = 1'b0;
        check("R6 read clears frame flag", stat_rdata, 8'h00);
        check("R9 irq low after read", {7'd0, irq_out}, 8'd0);
        next_step("R3 wrap to step0", 1, 0);
    endtask

    task automatic t_five_step;
        do_reset;
        do_ctrl(8'h80);
        next_step("R4 step0", 1, 1);
        next_step("R4 step1", 1, 0);
        next_step("R4 step2", 1, 1);
        next_step("R4 step3", 1, 0);
        next_step("R4 step4 silent", 0, 0);
        next_step("R4 wrap to step0", 1, 1);
        tick;
        check("R5 no frame flag in five-step", {7'd0, irq_out}, 8'd0);
    endtask

    task automatic t_inhibit;
        do_reset;
        do_ctrl(8'h40);
        for (int i = 0; i < 4; i++) next_step("R3 inhibited run", 1, i[0]);
        tick;
        check("R5 inhibit blocks flag", {stat_rdata[6], irq_out}, 2'b00);
        do_ctrl(8'h00);
        check("R5 nothing latched while inhibited", {7'd0, irq_out}, 8'd0);
        for (int i = 0; i < 4; i++) next_step("R3 uninhibited run", 1, i[0]);
        tick;
        check("R5 flag set after inhibit lifted", {7'd0, irq_out}, 8'd1);
        do_ctrl(8'h40);
        check("R6 inhibit write hides flag", {stat_rdata[6], irq_out}, 2'b00);
        do_ctrl(8'h00);
        check("R6 inhibit write cleared flag", {stat_rdata[6], irq_out}, 2'b00);
    endtask

    task automatic t_dmc;
        do_reset;
        dmc_irq_set = 1'b1;
        tick;
        dmc_irq_set = 1'b0;
        check("R8 dmc flag set", stat_rdata, 8'h80);
        check("R9 irq from dmc flag", {7'd0, irq_out}, 8'd1);
        enable_wr = 1'b1;
        tick;
        enable_wr = 1'b0;
        check("R8 enable write clears dmc flag", {stat_rdata[7], irq_out}, 2'b00);
        dmc_irq_set = 1'b1; enable_wr = 1'b1;
        tick;
        dmc_irq_set = 1'b0; enable_wr = 1'b0;
        check("R10 dmc set wins over enable write", stat_rdata, 8'h80);
        enable_wr = 1'b1;
        tick;
        enable_wr = 1'b0;
        for (int i = 0; i < 4; i++) next_step("R3 run for R10", 1, i[0]);
        stat_rd = 1'b1;
        tick;
        stat_rd = 1'b0;
        check("R10 frame set wins over read", stat_rdata, 8'h40);
    endtask

    task automatic t_status;
        do_reset;
        chan_active = 4'b1010; dmc_active = 1'b1;
        #1;
        check("R7 status activity bits", stat_rdata, 8'h1A);
        chan_active = 4'b0101; dmc_active = 1'b0;
        #1;
        check("R7 status activity bits alt", stat_rdata, 8'h05);
        chan_active = 4'b0000;
    endtask

    task automatic t_mode_switch;
        do_reset;
        next_step("R11 four-step step0", 1, 0);
        next_step("R11 four-step step1", 1, 0 | 1);
        do_ctrl(8'h80);
        next_step("R11 step2 decoded as five-step", 1, 1);
        next_step("R11 step3 five-step", 1, 0);
        do_ctrl(8'h00);
        next_step("R11 step4 under four-step", 1, 0);
        next_step("R11 back to step0", 1, 0);
        next_step("R11 step1 after switch", 1, 1);
    endtask

    initial begin
        #(8 * 20000);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        @(negedge clk);
        t_reset;
        t_four_step;
        t_five_step;
        t_inhibit;
        t_dmc;
        t_status;
        t_mode_switch;
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule